// File: doc/BRIEF.md
# PCI Interrupt Line Router

This block takes the four interrupt pins of each PCI slot and steers them onto sixteen legacy interrupt-controller input lines. It works in two stages. First, every slot pin is rotated by its slot's device number onto one of four shared interrupt signals, PIRQ A to D. Then four byte-wide route selectors, one per PIRQ, name the legacy line that each PIRQ drives. A legacy line is high while any PIRQ routed to it is high.

The selectors sit behind a small configuration port with byte enables: one 32-bit word holds all four, lane k belonging to PIRQ k. Internally the block keeps a 16-by-4 level matrix, with one bit for each pairing of legacy line and PIRQ. A small controller with two states runs it. In FOLLOW, each clock refreshes the matrix column of every PIRQ at the line it is routed to. Any write that touches a selector moves the controller to REBUILD. For that one cycle the matrix is cleared and filled again from the current PIRQ levels under the new routing, so no bit from the old routing survives. REBUILD returns to FOLLOW unless another selector write arrives in the same cycle. Selector values of 16 or more cut the PIRQ off from every line.

Top module: `pirq_router`

## Requirements
- R1: On reset every route selector is 0x80, a read at byte address 0x60 returns 0x80808080, and every irq_line bit is low.
- R2: A write whose cfg_addr[7:2] equals 0x18 (dword address 0x60) loads selector k (A=0, B=1, C=2, D=3) from cfg_wdata[8k+7:8k] when cfg_be[k] is set. Lanes without an enable keep their value. With cfg_be = 0xF all four selectors load at the same edge, and a read of that dword returns {D, C, B, A}.
- R3: A write to any other dword address changes no selector and no irq_line bit, and a read of any other dword returns 0.
- R4: slot_intx bit 4s+n is pin n (0 = INTA … 3 = INTD) of slot s, whose device number is FIRST_DEV+s. The pin drives PIRQ (n + FIRST_DEV + s − 1) mod 4, and each PIRQ level is the OR of all pins that map to it.
- R5: A selector value v below 16 routes its PIRQ to irq_line[v]. Each line is the OR of every PIRQ routed to it, and this holds for lines 0 and 15 as well.
- R6: A selector value of 16 or more disconnects its PIRQ, so that PIRQ drives no line.
- R7: A change on slot_intx shows on irq_line at the first rising clock edge after it and not before.
- R8: At the edge that writes a selector, irq_line still follows the old routing. At the next edge (the REBUILD cycle) the matrix is rebuilt, so irq_line follows the new routing and a line that lost its PIRQ drops.
- R9: Asserting reset in the middle of operation restores the R1 state at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_intx | input | 4*SLOTS | Slot interrupt pins, bit 4s+n = pin n of slot s |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte address (bits 1:0 ignored) |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for the addressed dword (combinational) |
| irq_line | output | 16 | Legacy interrupt line levels (registered) |

## Verification
The checker assumes that slot_intx and the configuration inputs hold known values from reset onward and change only between clock edges. It also assumes that every selector write is a single-cycle strobe, and its reference model takes the PIRQ levels as given by the swizzle stage. The bench drives all inputs on the falling edge and holds cfg_wr for exactly one cycle per write. It only ever writes the routing dword or one nearby foreign dword, so every check compares settled values against routing that the bench itself has written.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
    localparam int PIRQ_CNT = 4;
    localparam int LINE_CNT = 16;
    localparam int SEL_W    = 8;

    typedef logic [SEL_W-1:0] route_sel_t;

    localparam route_sel_t SEL_RESET = 8'h80;

    typedef enum logic [0:0] {
        TRK_FOLLOW  = 1'b0,
        TRK_REBUILD = 1'b1
    } trk_state_e;
endpackage

// File: rtl/pirq_swizzle.sv
module pirq_swizzle #(
    parameter int SLOTS     = 4,
    parameter int FIRST_DEV = 1,
    parameter int PIRQS     = 4
) (
    input  logic [SLOTS*4-1:0] slot_intx,
    output logic [PIRQS-1:0]   pirq_lvl
);
    localparam int PIN_CNT = 4;
    localparam int PQ_W    = $clog2(PIRQS);

    // pin n of device d lands on PIRQ (n + d - 1) mod PIRQS; +PIRQS-1 keeps it non-negative
    always_comb begin
        pirq_lvl = '0;
        for (int s = 0; s < SLOTS; s++) begin
            for (int n = 0; n < PIN_CNT; n++) begin
                pirq_lvl[PQ_W'((n + FIRST_DEV + s + PIRQS - 1) % PIRQS)] |= slot_intx[s*PIN_CNT + n];
            end
        end
    end
endmodule

// File: rtl/pirq_route_regs.sv
module pirq_route_regs
    import pirq_pkg::*;
#(
    parameter int         PIRQS      = PIRQ_CNT,
    parameter logic [7:0] ROUTE_BASE = 8'h60
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_wr,
    input  logic [7:0]             cfg_addr,
    input  logic [PIRQS-1:0]       cfg_be,
    input  logic [PIRQS*SEL_W-1:0] cfg_wdata,
    output logic [PIRQS*SEL_W-1:0] cfg_rdata,
    output logic [PIRQS*SEL_W-1:0] route_flat,
    output logic                   route_wr
);
    logic dw_hit;
    logic unused_addr_lsb;

    assign dw_hit          = (cfg_addr[7:2] == ROUTE_BASE[7:2]);
    assign unused_addr_lsb = ^cfg_addr[1:0];
    assign route_wr        = cfg_wr && dw_hit && (|cfg_be);
    assign cfg_rdata       = dw_hit ? route_flat : '0;

    for (genvar k = 0; k < PIRQS; k++) begin : g_lane
        route_sel_t sel_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sel_q <= SEL_RESET;
            end else if (cfg_wr && dw_hit && cfg_be[k]) begin
                sel_q <= cfg_wdata[k*SEL_W +: SEL_W];
            end
        end

        assign route_flat[k*SEL_W +: SEL_W] = sel_q;
    end
endmodule

// File: rtl/pirq_level_track.sv
module pirq_level_track
    import pirq_pkg::*;
#(
    parameter int LINES = LINE_CNT,
    parameter int PIRQS = PIRQ_CNT
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   route_wr,
    input  logic [PIRQS*SEL_W-1:0] route_flat,
    input  logic [PIRQS-1:0]       pirq_lvl,
    output logic [LINES-1:0]       irq_line,
    output logic                   rebuilding
);
    localparam int TRK_W   = LINES * PIRQS;
    localparam int TRK_IDX = $clog2(TRK_W);

    trk_state_e       state_q, state_d;
    logic [TRK_W-1:0] trk_q, trk_d;
    logic [LINES-1:0] line_d, line_q;

    // next-state logic
    always_comb begin
        unique case (state_q)
            TRK_FOLLOW:  state_d = route_wr ? TRK_REBUILD : TRK_FOLLOW;
            TRK_REBUILD: state_d = route_wr ? TRK_REBUILD : TRK_FOLLOW;
            default:     state_d = TRK_FOLLOW;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TRK_FOLLOW;
        else        state_q <= state_d;
    end

    // level matrix: cleared in REBUILD, then each PIRQ column refreshed at its route
    always_comb begin
        route_sel_t sel;
        int         idx;
        trk_d = (state_q == TRK_REBUILD) ? '0 : trk_q;
        for (int p = 0; p < PIRQS; p++) begin
            sel = route_flat[p*SEL_W +: SEL_W];
            idx = int'(sel) * PIRQS + p;
            if (int'(sel) < LINES) begin
                trk_d[TRK_IDX'(idx)] = pirq_lvl[p];
            end
        end
    end

    always_comb begin
        for (int l = 0; l < LINES; l++) begin
            line_d[l] = |trk_d[l*PIRQS +: PIRQS];
        end
    end

    // output process: matrix and line registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_q  <= '0;
            line_q <= '0;
        end else begin
            trk_q  <= trk_d;
            line_q <= line_d;
        end
    end

    assign irq_line   = line_q;
    assign rebuilding = (state_q == TRK_REBUILD);
endmodule

// File: rtl/pirq_router.sv
module pirq_router
    import pirq_pkg::*;
#(
    parameter int         SLOTS      = 4,
    parameter int         FIRST_DEV  = 1,
    parameter logic [7:0] ROUTE_BASE = 8'h60
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [SLOTS*4-1:0]   slot_intx,
    input  logic                 cfg_wr,
    input  logic [7:0]           cfg_addr,
    input  logic [3:0]           cfg_be,
    input  logic [31:0]          cfg_wdata,
    output logic [31:0]          cfg_rdata,
    output logic [LINE_CNT-1:0]  irq_line
);
    logic [PIRQ_CNT-1:0]       pirq_lvl;
    logic [PIRQ_CNT*SEL_W-1:0] route_flat;
    logic                      route_wr;
    logic                      rebuilding;

    pirq_swizzle #(
        .SLOTS     (SLOTS),
        .FIRST_DEV (FIRST_DEV),
        .PIRQS     (PIRQ_CNT)
    ) u_swizzle (
        .slot_intx (slot_intx),
        .pirq_lvl  (pirq_lvl)
    );

    pirq_route_regs #(
        .PIRQS      (PIRQ_CNT),
        .ROUTE_BASE (ROUTE_BASE)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr     (cfg_wr),
        .cfg_addr   (cfg_addr),
        .cfg_be     (cfg_be),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .route_flat (route_flat),
        .route_wr   (route_wr)
    );

    pirq_level_track #(
        .LINES (LINE_CNT),
        .PIRQS (PIRQ_CNT)
    ) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .route_wr   (route_wr),
        .route_flat (route_flat),
        .pirq_lvl   (pirq_lvl),
        .irq_line   (irq_line),
        .rebuilding (rebuilding)
    );
endmodule

// File: rtl/pirq_router_chk.sv
module pirq_router_chk
    import pirq_pkg::*;
#(
    parameter logic [7:0] ROUTE_BASE = 8'h60
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      cfg_wr,
    input logic [7:0]                cfg_addr,
    input logic [3:0]                cfg_be,
    input logic [31:0]               cfg_wdata,
    input logic [PIRQ_CNT*SEL_W-1:0] route_flat,
    input logic                      route_wr,
    input logic [PIRQ_CNT-1:0]       pirq_lvl,
    input logic                      rebuilding,
    input logic [LINE_CNT-1:0]       irq_line
);
    localparam int LINE_W = $clog2(LINE_CNT);

    logic [LINE_CNT-1:0] expect_vec;
    logic                all_off;
    logic                unused_addr_low;

    assign unused_addr_low = ^cfg_addr[1:0];

    always_comb begin
        route_sel_t sel;
        expect_vec = '0;
        all_off    = 1'b1;
        for (int p = 0; p < PIRQ_CNT; p++) begin
            sel = route_flat[p*SEL_W +: SEL_W];
            if (int'(sel) < LINE_CNT) begin
                expect_vec[sel[LINE_W-1:0]] |= pirq_lvl[p];
                all_off = 1'b0;
            end
        end
    end

    // R2
    route_full_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_addr[7:2] == ROUTE_BASE[7:2] && cfg_be == 4'hF)
        |=> route_flat == $past(cfg_wdata));

    // R3
    route_foreign_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_addr[7:2] != ROUTE_BASE[7:2]) |=> $stable(route_flat));

    // R6
    line_disconnect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        all_off |=> irq_line == '0);

    // R5 R7
    line_model_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> irq_line == $past(expect_vec));

    // R8
    rebuild_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        route_wr |=> rebuilding);
endmodule

bind pirq_router pirq_router_chk #(.ROUTE_BASE(ROUTE_BASE)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr     (cfg_wr),
    .cfg_addr   (cfg_addr),
    .cfg_be     (cfg_be),
    .cfg_wdata  (cfg_wdata),
    .route_flat (route_flat),
    .route_wr   (route_wr),
    .pirq_lvl   (pirq_lvl),
    .rebuilding (rebuilding),
    .irq_line   (irq_line)
);

// File: tb/pirq_router_bench.sv
module pirq_router_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] slot_intx;
    logic        cfg_wr;
    logic [7:0]  cfg_addr;
    logic [3:0]  cfg_be;
    logic [31:0] cfg_wdata;
    logic [31:0] cfg_rdata;
    logic [15:0] irq_line;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    pirq_router u_pirq_router (
        .clk       (clk),
        .rst_n     (rst_n),
        .slot_intx (slot_intx),
        .cfg_wr    (cfg_wr),
        .cfg_addr  (cfg_addr),
        .cfg_be    (cfg_be),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .irq_line  (irq_line)
    );

    // {slot_intx, expected irq_line} with A->3, B->5, C->3, D off (R4, R5, R6)
    localparam logic [31:0] VEC [9] = '{
        {16'h0000, 16'h0000},
        {16'h0001, 16'h0008},
        {16'h0002, 16'h0020},
        {16'h0010, 16'h0020},
        {16'h0200, 16'h0000},
        {16'h8000, 16'h0008},
        {16'h0210, 16'h0020},
        {16'h4100, 16'h0028},
        {16'hFFFF, 16'h0028}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        cfg_wr    = 1'b1;
        cfg_addr  = a;
        cfg_be    = be;
        cfg_wdata = d;
        @(negedge clk);
        cfg_wr    = 1'b0;
        cfg_be    = 4'h0;
    endtask

    task automatic cfg_read(input logic [7:0] a, output logic [31:0] d);
        cfg_addr = a;
        #1;
        d = cfg_rdata;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        rst_n     = 1'b0;
        slot_intx = '0;
        cfg_wr    = 1'b0;
        cfg_addr  = 8'h60;
        cfg_be    = 4'h0;
        cfg_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        cfg_read(8'h60, rd);
        check("R1 selectors", rd, 32'h8080_8080);
        check("R1 lines", {16'h0, irq_line}, 32'h0);

        // R2 single lane then full word
        cfg_write(8'h60, 4'b0010, 32'h0000_0500);
        cfg_read(8'h60, rd);
        check("R2 lane B only", rd, 32'h8080_0580);
        cfg_write(8'h60, 4'hF, 32'h8003_0503);
        cfg_read(8'h60, rd);
        check("R2 all lanes", rd, 32'h8003_0503);
        @(negedge clk);

        // R4 R5 R6 table walk
        for (int i = 0; i < 9; i++) begin
            slot_intx = VEC[i][31:16];
            @(negedge clk);
            check($sformatf("R4/R5 vector %0d", i), {16'h0, irq_line}, {16'h0, VEC[i][15:0]});
        end

        // R7 timing: no change before the edge, change after it
        slot_intx = 16'h0000;
        #1;
        check("R7 before edge", {16'h0, irq_line}, 32'h0000_0028);
        @(negedge clk);
        check("R7 after edge", {16'h0, irq_line}, 32'h0);

        // R3 foreign dword write
        slot_intx = 16'h0001;
        cfg_write(8'h64, 4'hF, 32'h0101_0101);
        cfg_read(8'h64, rd);
        check("R3 foreign read", rd, 32'h0);
        cfg_read(8'h60, rd);
        check("R3 selectors kept", rd, 32'h8003_0503);
        @(negedge clk);
        check("R3 lines kept", {16'h0, irq_line}, 32'h0000_0008);

        // R8 reroute A from 3 to 7: old routing one edge, new routing the next
        cfg_write(8'h60, 4'b0001, 32'h0000_0007);
        check("R8 write edge", {16'h0, irq_line}, 32'h0000_0008);
        @(negedge clk);
        check("R8 rebuild edge", {16'h0, irq_line}, 32'h0000_0080);

        // R6 disconnect with value 16
        cfg_write(8'h60, 4'b0001, 32'h0000_0010);
        @(negedge clk);
        check("R6 value 16", {16'h0, irq_line}, 32'h0);

        // R5 boundary lines 15 and 0
        slot_intx = 16'h0003;
        cfg_write(8'h60, 4'b0011, 32'h0000_000F);
        @(negedge clk);
        check("R5 lines 15 and 0", {16'h0, irq_line}, 32'h0000_8001);

        // R9 reset mid-run
        rst_n = 1'b0;
        cfg_addr = 8'h60;
        #1;
        check("R9 lines in reset", {16'h0, irq_line}, 32'h0);
        check("R9 selectors in reset", cfg_rdata, 32'h8080_8080);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 lines after reset", {16'h0, irq_line}, 32'h0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule